// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block is the integer execution datapath of a 64-bit core. It takes two 64-bit operands and a 7-bit operation code, and it returns a 64-bit result together with a branch-taken flag. Bits [6:4] of the code pick an operation group:

- shifts and single-bit operations
- 32-bit word arithmetic
- add variants
- subtract and compare
- logic and byte packing
- reduced logic
- branch compares

Besides the usual integer operations, the block offers fused forms that save a separate instruction:

- an add that uses only the lowest bit of the first operand
- adds of the first operand shifted right by 29 to 32
- a merged upper-immediate-plus-immediate add
- logic results cut down to one bit or to a zero-extended halfword

Operations enter and leave on valid/ready streams. The input stream carries `in_op`, `in_src1` and `in_src2`, and a transfer happens on a rising edge where `in_valid` and `in_ready` are both high. The output stream carries `out_result` and `out_taken`.

With the default `OUT_REG = 1`, each result sits in a single output register:

- The result appears on the clock edge after the input is accepted.
- The result is held unchanged while `out_ready` is low.
- `in_ready` is high whenever the register is empty or is being drained in the same cycle, so full throughput continues under a constantly ready consumer.

With `OUT_REG = 0`, the block is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `fused_alu64`

## Requirements
- R1: After reset (`rst_n` low) and until the first accepted input, `out_valid` is 0.
- R2: With `OUT_REG=1`, an input accepted on an edge gives `out_valid`=1 with its result after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_result`/`out_taken` hold. With no accept and the output drained, `out_valid` returns to 0.
- R3: Group 000 (shift amount s=src2[5:0]). 0000 gives zext(src1[31:0])<<s. 0001 gives shift left. 0101 gives logical shift right. 0111 gives arithmetic shift right. 0010 clears bit s, 0011 sets bit s, and 0100 flips bit s by XOR with a one-hot mask. 0110 gives bit s of src1 zero-extended to 64 bits.
- R4: Rotates combine two opposite shifts, by the amount and by the width minus the amount. Code 000_1001 rotates left and 000_1011 rotates right by src2[5:0]. Code 001_1100 rotates left and 001_1101 rotates right the low 32 bits by src2[4:0], and the result is sign-extended.
- R5: Group 001 word operations, sign-extended from bit 31. 0000 gives src1+src2. 0001 gives src1[0]+src2. 0010 gives src1-src2. 0011 gives sext12(src2[11:0]) + {src2[31:12],12'b0}. With s=src2[4:0]: 1000 shifts left by s, 1001 shifts src1[31:0] right logically by s, and 1010 shifts src1[31:0] right arithmetically by s. Codes 0100 to 0111 use the 32-bit sum: 0100 returns bit 0, 0101 the low byte zero-extended, 0110 the low 16 bits zero-extended, and 0111 the low 16 bits sign-extended.
- R6: Group 010 adds. 0000 gives zext(src1[31:0])+src2, 0001 src1+src2, and 0010 src1[0]+src2. 0011 gives sext(src2[11:0]) + {src2[63:12],12'b0}. Codes 0100 to 0111 give (src1>>29)+src2, (src1>>30)+src2, (src1>>31)+src2 and (src1>>32)+src2. Codes 1001, 1011, 1101 and 1111 give (src1<<1), (src1<<2), (src1<<3) and (src1<<4) plus src2. Codes 1000, 1010 and 1100 do the same for shifts of 1, 2 and 3 with src1[31:0] zero-extended first.
- R7: Group 011. 0000 gives src1-src2. 0001 gives the unsigned less-than result and 0010 the signed less-than result, as 0 or 1. 0100 gives the unsigned maximum, 0101 the unsigned minimum, 0110 the signed maximum and 0111 the signed minimum.
- R8: Group 100. 0000 and, 0001 and-not, 0010 or, 0011 or-not, 0100 xor, 0101 xnor. 0110 sets each nonzero byte to 0xFF. 1000 sign-extends src1[7:0] and 1010 sign-extends src1[15:0]. 1001 gives {src2[7:0],src1[7:0]} zero-extended. 1011 gives sext32({src2[15:0],src1[15:0]}). Group 101: 0000 reverses the bits inside each byte, 0001 reverses the byte order, and 0010 gives {src2[31:0],src1[31:0]}.
- R9: Group 110 with op[3]=0 applies the logic operation {100,op[3:1],0} (and, or, xor, byte-or-combine). If op[0]=0 it returns bit 0 of that result. If op[0]=1 it returns the low 16 bits zero-extended.
- R10: Group 111 codes are 0000 eq, 0010 ne, 1000 signed lt, 1010 signed ge, 1100 unsigned lt and 1110 unsigned ge. `out_taken` is the compare outcome and `out_result` is 0.
- R11: Every unlisted code gives result 0 and taken 0. `out_taken` is 0 for every non-branch code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation |
| in_op | input | 7 | Operation code |
| in_src1 | input | 64 | First operand |
| in_src2 | input | 64 | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result value |
| out_taken | output | 1 | Branch compare outcome |

## Verification
The only state in the block is the output register, so the bench concentrates on what a wrong register state would show. A lost or stuck valid bit shows up at `out_valid` on the edge right after the accept. A register that reloads under back-pressure changes `out_result` one cycle into the stall. Decode faults are purely combinational and show up in the result of the very next operation of the affected code. For that reason, every one of the 128 codes is driven with corner operands (zero, all-ones, most negative) and with random operands.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
  localparam int DW  = 64;
  localparam int HW  = DW / 2;
  localparam int OPW = 7;
  localparam int SHW = $clog2(DW);
  localparam int NB  = DW / 8;

  localparam logic [2:0] GRP_SHIFT = 3'b000;
  localparam logic [2:0] GRP_WORD  = 3'b001;
  localparam logic [2:0] GRP_ADD   = 3'b010;
  localparam logic [2:0] GRP_SUB   = 3'b011;
  localparam logic [2:0] GRP_LOGIC = 3'b100;
  localparam logic [2:0] GRP_MISC  = 3'b101;
  localparam logic [2:0] GRP_NARROW = 3'b110;
  localparam logic [2:0] GRP_BRANCH = 3'b111;

  function automatic logic [DW-1:0] sext_half(input logic [HW-1:0] v);
    return {{HW{v[HW-1]}}, v};
  endfunction
endpackage

// File: rtl/fused_alu_shiftword.sv
module fused_alu_shiftword
  import fused_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [HW-1:0]  b_lo,
  output logic [DW-1:0]  res
);
  localparam int SHWW = $clog2(HW);

  logic [SHW-1:0]  sh;
  logic [SHWW-1:0] shw;
  logic [DW-1:0]   onehot, rol_v, ror_v;
  logic [HW-1:0]   aw, sum_w, odd_w, dif_w, lui_w, sll_w, srl_w, sra_w, rol_w, ror_w;

  assign sh     = b_lo[SHW-1:0];
  assign shw    = b_lo[SHWW-1:0];
  assign aw     = a[HW-1:0];
  assign onehot = {{(DW-1){1'b0}}, 1'b1} << sh;
  assign rol_v  = (a << sh) | (a >> (7'(DW) - {1'b0, sh}));
  assign ror_v  = (a >> sh) | (a << (7'(DW) - {1'b0, sh}));
  assign sum_w  = aw + b_lo;
  assign odd_w  = {{(HW-1){1'b0}}, a[0]} + b_lo;
  assign dif_w  = aw - b_lo;
  assign lui_w  = {{20{b_lo[11]}}, b_lo[11:0]} + {b_lo[HW-1:12], 12'b0};
  assign sll_w  = aw << shw;
  assign srl_w  = aw >> shw;
  assign sra_w  = $unsigned($signed(aw) >>> shw);
  assign rol_w  = (aw << shw) | (aw >> (6'(HW) - {1'b0, shw}));
  assign ror_w  = (aw >> shw) | (aw << (6'(HW) - {1'b0, shw}));

  always_comb begin
    res = '0;
    if (op[6:4] == GRP_SHIFT) begin
      case (op[3:0])
        4'b0000: res = {{HW{1'b0}}, aw} << sh;
        4'b0001: res = a << sh;
        4'b0010: res = a & ~onehot;
        4'b0011: res = a | onehot;
        4'b0100: res = a ^ onehot;
        4'b0101: res = a >> sh;
        4'b0110: res = {{(DW-1){1'b0}}, |(a & onehot)};
        4'b0111: res = $unsigned($signed(a) >>> sh);
        4'b1001: res = rol_v;
        4'b1011: res = ror_v;
        default: res = '0;
      endcase
    end else if (op[6:4] == GRP_WORD) begin
      case (op[3:0])
        4'b0000: res = sext_half(sum_w);
        4'b0001: res = sext_half(odd_w);
        4'b0010: res = sext_half(dif_w);
        4'b0011: res = sext_half(lui_w);
        4'b0100: res = {{(DW-1){1'b0}}, sum_w[0]};
        4'b0101: res = {{(DW-8){1'b0}}, sum_w[7:0]};
        4'b0110: res = {{(DW-16){1'b0}}, sum_w[15:0]};
        4'b0111: res = {{(DW-16){sum_w[15]}}, sum_w[15:0]};
        4'b1000: res = sext_half(sll_w);
        4'b1001: res = sext_half(srl_w);
        4'b1010: res = sext_half(sra_w);
        4'b1100: res = sext_half(rol_w);
        4'b1101: res = sext_half(ror_w);
        default: res = '0;
      endcase
    end
  end
endmodule

// File: rtl/fused_alu_arith.sv
module fused_alu_arith
  import fused_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  res,
  output logic           taken
);
  logic [DW-1:0] a_zw, sh_src, sh_val, lui_v, dif;
  logic          ult, slt, eq;

  assign a_zw  = {{HW{1'b0}}, a[HW-1:0]};
  assign lui_v = {{(DW-12){b[11]}}, b[11:0]} + {b[DW-1:12], 12'b0};
  assign dif   = a - b;
  assign ult   = a < b;
  assign slt   = $signed(a) < $signed(b);
  assign eq    = (a == b);

  // shift-add: odd low bit or code 1111 means full width; shift count from op[2:1]
  assign sh_src = (op[0] || op[3:0] == 4'b1111) ? a : a_zw;
  assign sh_val = (op[3:0] == 4'b1111) ? (a << 4) : (sh_src << ({1'b0, op[2:1]} + 3'd1));

  always_comb begin
    res   = '0;
    taken = 1'b0;
    case (op[6:4])
      GRP_ADD: begin
        case (op[3:0])
          4'b0000: res = a_zw + b;
          4'b0001: res = a + b;
          4'b0010: res = {{(DW-1){1'b0}}, a[0]} + b;
          4'b0011: res = lui_v;
          4'b0100: res = (a >> 29) + b;
          4'b0101: res = (a >> 30) + b;
          4'b0110: res = (a >> 31) + b;
          4'b0111: res = (a >> 32) + b;
          4'b1110: res = '0;
          default: res = sh_val + b;
        endcase
      end
      GRP_SUB: begin
        case (op[3:0])
          4'b0000: res = dif;
          4'b0001: res = {{(DW-1){1'b0}}, ult};
          4'b0010: res = {{(DW-1){1'b0}}, slt};
          4'b0100: res = ult ? b : a;
          4'b0101: res = ult ? a : b;
          4'b0110: res = slt ? b : a;
          4'b0111: res = slt ? a : b;
          default: res = '0;
        endcase
      end
      GRP_BRANCH: begin
        case (op[3:0])
          4'b0000: taken = eq;
          4'b0010: taken = !eq;
          4'b1000: taken = slt;
          4'b1010: taken = !slt;
          4'b1100: taken = ult;
          4'b1110: taken = !ult;
          default: taken = 1'b0;
        endcase
      end
      default: begin
        res   = '0;
        taken = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fused_alu_logic.sv
module fused_alu_logic
  import fused_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  res
);
  logic [DW-1:0] orc, brev, bswap, basic;
  logic [2:0]    sel;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign orc[8*i +: 8]   = {8{|a[8*i +: 8]}};
    assign bswap[8*i +: 8] = a[8*(NB-1-i) +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign brev[8*i + j] = a[8*i + 7 - j];
    end
  end

  // even-coded logic operations share a selector: op[3:1]
  assign sel = op[3:1];
  always_comb begin
    case (sel)
      3'b000:  basic = a & b;
      3'b001:  basic = a | b;
      3'b010:  basic = a ^ b;
      3'b011:  basic = orc;
      default: basic = '0;
    endcase
  end

  always_comb begin
    res = '0;
    case (op[6:4])
      GRP_LOGIC: begin
        case (op[3:0])
          4'b0000, 4'b0010, 4'b0100, 4'b0110: res = basic;
          4'b0001: res = a & ~b;
          4'b0011: res = a | ~b;
          4'b0101: res = ~(a ^ b);
          4'b1000: res = {{(DW-8){a[7]}}, a[7:0]};
          4'b1001: res = {{(DW-16){1'b0}}, b[7:0], a[7:0]};
          4'b1010: res = {{(DW-16){a[15]}}, a[15:0]};
          4'b1011: res = sext_half({b[15:0], a[15:0]});
          default: res = '0;
        endcase
      end
      GRP_MISC: begin
        case (op[3:0])
          4'b0000: res = brev;
          4'b0001: res = bswap;
          4'b0010: res = {b[HW-1:0], a[HW-1:0]};
          default: res = '0;
        endcase
      end
      GRP_NARROW: begin
        if (!op[3]) res = op[0] ? {{(DW-16){1'b0}}, basic[15:0]}
                                : {{(DW-1){1'b0}}, basic[0]};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/fused_alu64.sv
module fused_alu64
  import fused_alu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_src1,
  input  logic [DW-1:0]  in_src2,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_result,
  output logic           out_taken
);
  logic [DW-1:0] r_sw, r_ar, r_lg, r_all;
  logic          t_ar;

  fused_alu_shiftword u_sw (.op(in_op), .a(in_src1), .b_lo(in_src2[HW-1:0]), .res(r_sw));
  fused_alu_arith     u_ar (.op(in_op), .a(in_src1), .b(in_src2), .res(r_ar), .taken(t_ar));
  fused_alu_logic     u_lg (.op(in_op), .a(in_src1), .b(in_src2), .res(r_lg));

  // each unit drives zero outside its own groups
  assign r_all = r_sw | r_ar | r_lg;

  if (OUT_REG) begin : g_reg
    logic          vld_q, tkn_q;
    logic [DW-1:0] res_q;
    logic          load;

    assign in_ready = !vld_q || out_ready;
    assign load     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q <= '0;
        tkn_q <= 1'b0;
      end else if (load) begin
        res_q <= r_all;
        tkn_q <= t_ar;
      end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;
    assign out_taken  = tkn_q;
  end else begin : g_comb
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_result = r_all;
    assign out_taken  = t_ar;
  end
endmodule

// File: rtl/fused_alu_checker.sv
module fused_alu_checker #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [6:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_taken
);
  logic acc;
  assign acc = in_valid && in_ready;

  if (OUT_REG) begin : g_chk
    a_r2_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);
    a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_taken)));
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && (!out_valid || out_ready)) |=> !out_valid);
    a_r10_branch_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op[6:4] == 3'b111) |=> (out_result == 64'd0));
    a_r11_taken_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op[6:4] != 3'b111) |=> !out_taken);
    a_r9_lsb_width: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op[6:4] == 3'b110 && !in_op[0]) |=> (out_result[63:1] == 63'd0));
    a_r9_half_width: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op[6:4] == 3'b110 && in_op[0]) |=> (out_result[63:16] == 48'd0));
  end
endmodule

bind fused_alu64 fused_alu_checker #(.OUT_REG(OUT_REG)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result), .out_taken(out_taken)
);

// File: tb/test_fused_alu64.sv
module test_fused_alu64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_op = '0;
  logic [63:0] in_src1 = '0, in_src2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_taken;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fused_alu64 #(.OUT_REG(1'b1)) i_fused_alu64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src1(in_src1), .in_src2(in_src2), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_taken(out_taken)
  );

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] rotl(input logic [63:0] v, input int n, input int w);
    logic [63:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = (w == 64) ? {r[62:0], r[63]} : {32'd0, r[30:0], r[31]};
    return r;
  endfunction

  function automatic logic [63:0] lgc(input logic [2:0] s, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] o;
    case (s)
      3'd0: o = a & b;
      3'd1: o = a | b;
      3'd2: o = a ^ b;
      3'd3: begin
        for (int i = 0; i < 8; i++) o[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
      end
      default: o = 0;
    endcase
    return o;
  endfunction

  // reference model written from the requirements; tag names the requirement
  function automatic void model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic t, output string tag);
    int s, sw;
    logic [31:0] w;
    logic [63:0] m;
    s = int'(b[5:0]);
    sw = int'(b[4:0]);
    r = 0; t = 0; tag = "R11";
    w = a[31:0] + b[31:0];
    case (op)
      7'h00: begin r = {32'd0, a[31:0]} << s; tag = "R3"; end
      7'h01: begin r = a << s; tag = "R3"; end
      7'h02: begin r = a; r[s] = 1'b0; tag = "R3"; end
      7'h03: begin r = a; r[s] = 1'b1; tag = "R3"; end
      7'h04: begin r = a; r[s] = ~a[s]; tag = "R3"; end
      7'h05: begin r = a >> s; tag = "R3"; end
      7'h06: begin r = {63'd0, a[s]}; tag = "R3"; end
      7'h07: begin r = $unsigned($signed(a) >>> s); tag = "R3"; end
      7'h09: begin r = rotl(a, s, 64); tag = "R4"; end
      7'h0B: begin r = rotl(a, (64 - s) % 64, 64); tag = "R4"; end
      7'h10: begin r = sx32(w); tag = "R5"; end
      7'h11: begin r = sx32({31'd0, a[0]} + b[31:0]); tag = "R5"; end
      7'h12: begin r = sx32(a[31:0] - b[31:0]); tag = "R5"; end
      7'h13: begin r = sx32({{20{b[11]}}, b[11:0]} + {b[31:12], 12'd0}); tag = "R5"; end
      7'h14: begin r = {63'd0, w[0]}; tag = "R5"; end
      7'h15: begin r = {56'd0, w[7:0]}; tag = "R5"; end
      7'h16: begin r = {48'd0, w[15:0]}; tag = "R5"; end
      7'h17: begin r = {{48{w[15]}}, w[15:0]}; tag = "R5"; end
      7'h18: begin m = {32'd0, a[31:0]} << sw; r = sx32(m[31:0]); tag = "R5"; end
      7'h19: begin r = sx32(a[31:0] >> sw); tag = "R5"; end
      7'h1A: begin r = sx32($unsigned($signed(a[31:0]) >>> sw)); tag = "R5"; end
      7'h1C: begin m = rotl({32'd0, a[31:0]}, sw, 32); r = sx32(m[31:0]); tag = "R4"; end
      7'h1D: begin m = rotl({32'd0, a[31:0]}, (32 - sw) % 32, 32); r = sx32(m[31:0]); tag = "R4"; end
      7'h20: begin r = {32'd0, a[31:0]} + b; tag = "R6"; end
      7'h21: begin r = a + b; tag = "R6"; end
      7'h22: begin r = {63'd0, a[0]} + b; tag = "R6"; end
      7'h23: begin r = {{52{b[11]}}, b[11:0]} + {b[63:12], 12'd0}; tag = "R6"; end
      7'h24, 7'h25, 7'h26, 7'h27: begin r = (a >> (29 + int'(op[1:0]))) + b; tag = "R6"; end
      7'h28: begin r = ({32'd0, a[31:0]} << 1) + b; tag = "R6"; end
      7'h29: begin r = (a << 1) + b; tag = "R6"; end
      7'h2A: begin r = ({32'd0, a[31:0]} << 2) + b; tag = "R6"; end
      7'h2B: begin r = (a << 2) + b; tag = "R6"; end
      7'h2C: begin r = ({32'd0, a[31:0]} << 3) + b; tag = "R6"; end
      7'h2D: begin r = (a << 3) + b; tag = "R6"; end
      7'h2F: begin r = (a << 4) + b; tag = "R6"; end
      7'h30: begin r = a - b; tag = "R7"; end
      7'h31: begin r = (a < b) ? 1 : 0; tag = "R7"; end
      7'h32: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R7"; end
      7'h34: begin r = (a > b) ? a : b; tag = "R7"; end
      7'h35: begin r = (a < b) ? a : b; tag = "R7"; end
      7'h36: begin r = ($signed(a) > $signed(b)) ? a : b; tag = "R7"; end
      7'h37: begin r = ($signed(a) < $signed(b)) ? a : b; tag = "R7"; end
      7'h40, 7'h42, 7'h44, 7'h46: begin r = lgc(op[3:1], a, b); tag = "R8"; end
      7'h41: begin r = a & ~b; tag = "R8"; end
      7'h43: begin r = a | ~b; tag = "R8"; end
      7'h45: begin r = ~(a ^ b); tag = "R8"; end
      7'h48: begin r = {{56{a[7]}}, a[7:0]}; tag = "R8"; end
      7'h49: begin r = {48'd0, b[7:0], a[7:0]}; tag = "R8"; end
      7'h4A: begin r = {{48{a[15]}}, a[15:0]}; tag = "R8"; end
      7'h4B: begin r = sx32({b[15:0], a[15:0]}); tag = "R8"; end
      7'h50: begin for (int i = 0; i < 64; i++) r[i] = a[(i / 8) * 8 + 7 - (i % 8)]; tag = "R8"; end
      7'h51: begin for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8]; tag = "R8"; end
      7'h52: begin r = {b[31:0], a[31:0]}; tag = "R8"; end
      7'h70: begin t = (a == b); tag = "R10"; end
      7'h72: begin t = (a != b); tag = "R10"; end
      7'h78: begin t = $signed(a) < $signed(b); tag = "R10"; end
      7'h7A: begin t = $signed(a) >= $signed(b); tag = "R10"; end
      7'h7C: begin t = a < b; tag = "R10"; end
      7'h7E: begin t = a >= b; tag = "R10"; end
      default: begin
        if (op[6:4] == 3'b110 && !op[3]) begin
          m = lgc(op[3:1], a, b);
          r = op[0] ? {48'd0, m[15:0]} : {63'd0, m[0]};
          tag = "R9";
        end
      end
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic et;
    string tg;
    model(op, a, b, er, et, tg);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src1 = a; in_src2 = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2", {63'd0, out_valid}, 64'd1);
    chk(out_result == er && out_taken == et, tg, {out_result[62:0], out_taken}, {er[62:0], et});
  endtask

  initial begin
    logic [63:0] cv [3];
    cv[0] = 64'd0; cv[1] = '1; cv[2] = 64'h8000_0000_0000_0000;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);

    // directed corner cases
    run_op(7'h09, 64'h8000_0000_0000_0001, 64'd0);          // R4 rotate by zero
    run_op(7'h0B, 64'h0000_0000_0000_0001, 64'd1);          // R4 rotate right wraps
    run_op(7'h13, 64'd0, 64'h0000_0000_7FFF_F800);          // R5 merged add sign through bit 31
    run_op(7'h23, 64'd0, 64'h0000_0000_0000_0800);          // R6 negative 12-bit immediate
    run_op(7'h4B, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF); // R8 packw sign
    run_op(7'h7A, 64'h8000_0000_0000_0000, 64'd1);          // R10 signed ge false

    // every code with corner and random operands
    for (int op = 0; op < 128; op++) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          run_op(7'(op), cv[i], cv[j]);
      for (int k = 0; k < 12; k++) begin
        logic [63:0] ra, rb;
        ra = {$urandom, $urandom};
        rb = (k % 3 == 0) ? {32'd0, $urandom} : {$urandom, $urandom};
        if (k % 4 == 1) rb = ra;
        run_op(7'(op), ra, rb);
      end
    end

    // back-pressure: R2
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 7'h21; in_src1 = 64'd1; in_src2 = 64'd2;
    @(negedge clk);
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R2", {62'd0, out_valid, in_ready}, 64'd2);
    in_src1 = 64'd5; in_src2 = 64'd5;
    @(negedge clk);
    chk(out_result == 64'd3 && out_valid == 1'b1, "R2", out_result, 64'd3);
    @(negedge clk);
    chk(out_result == 64'd3, "R2", out_result, 64'd3);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_result == 64'd10 && out_valid == 1'b1, "R2", out_result, 64'd10);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", {63'd0, out_valid}, 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule